// File: doc/BRIEF.md
# Truth-Table Pattern Trigger

This block decides, sample by sample, whether a 16-channel logic capture stream has reached a programmed state. The channels are cut into four groups of four. Each group's 4-bit value picks one bit out of that group's own 16-entry truth table. The trigger condition holds when all four picked bits are 1. Any mix of "must be 0", "must be 1" and "don't care" per channel can be expressed this way. Because the tables are free-form, other per-group pattern sets can be expressed as well.

Software fills the tables through a two-address byte port, and the tables are loaded transposed. The host first writes row data to the data address. It then writes a row command to the select address. That command stores bit `i` of every match table in one step. Once the sixteen rows are in, the host writes a six-byte parameter block to the data address. Its result-select field switches the plain state-match trigger on. Capture logic pulses `arm`. The block then emits a single one-cycle `trig_pulse` on the first qualifying sample and holds `trig_hit` until it is armed again.

Top module: `pat_trig`

## Requirements
- R1: After reset every table entry is 0, the trigger is disabled, and `trig_pulse`, `trig_hit` and `trig_armed` are 0. No sample fires a trigger until tables and parameters have been loaded.
- R2: Channel group n (channels 4n to 4n+3) selects bit j of table n, where j is the group's 4-bit value. A sample matches when the selected bit of all four tables is 1.
- R3: A data-address write (`wr_sel`=0) that is the first byte after a select write latches a row byte. A select-address write (`wr_sel`=1) whose upper nibble is 3 then stores bit n of the row byte into entry i of table n, where i is the lower nibble. Row-byte bits 7:4 and the second row byte have no effect on matching.
- R4: A select write whose upper nibble is not 3 leaves every table unchanged.
- R5: A row command issued without new data bytes stores the most recently latched row byte.
- R6: Data writes are counted from the last select write. The sixth byte completes a parameter block. Bits 3:2 of the block's second byte are the result select, and the trigger is enabled only while the last completed block carried the value 3.
- R7: A qualifying sample (armed, `smp_vld` high, match, trigger enabled) gives `trig_pulse` high in the cycle right after the clock edge that sees it.
- R8: `trig_pulse` is high for exactly one cycle per arming. After it, `trig_hit` stays 1 and `trig_armed` stays 0 until the next `arm`, and further matching samples produce no pulse.
- R9: A sample with `smp_vld` low never fires and leaves the block armed.
- R10: `arm` clears `trig_hit` and arms the block. It takes priority over a matching sample in the same cycle, which then produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: data address, 1: select address |
| wr_data | input | 8 | Write byte |
| arm | input | 1 | Arm pulse; clears a previous hit |
| smp_vld | input | 1 | Sample qualifier |
| smp | input | 16 | Current sample, channel c on bit c |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| trig_hit | output | 1 | Trigger has fired since the last arm |
| trig_armed | output | 1 | Waiting for a qualifying sample |

## Verification
The bench loads tables built from mask/value pairs, plus one free-form table set. It sweeps thousands of spread samples together with the exact target and every single-bit neighbour of it. A swapped channel group or a transposition error would therefore show up as stray or missing pulses. It probes a row command with no fresh data and a select write with the wrong upper nibble. Getting either wrong would silently alter a table entry that the next sample exposes. It also covers a parameter block whose result select is not 3, `arm` arriving together with a matching sample, and invalid samples while armed. A design that fires more than once per arming, or too early, fails the pulse-timing checks.

// File: rtl/pat_trig_pkg.sv
package pat_trig_pkg;

    localparam int NIB_W       = 4;
    localparam int NUM_NIB     = 4;
    localparam int CH_W        = NIB_W * NUM_NIB;
    localparam int TBL_D       = 1 << NIB_W;
    localparam int IDX_W       = NIB_W;
    localparam int BYTE_W      = 8;
    localparam int PARAM_BYTES = 6;
    localparam int PTR_W       = $clog2(PARAM_BYTES);
    localparam int RES_LSB     = 2;

    localparam logic [3:0] OP_ROW = 4'h3;

    typedef enum logic [1:0] {
        RES_OFF0  = 2'd0,
        RES_OFF1  = 2'd1,
        RES_OFF2  = 2'd2,
        RES_EVENT = 2'd3
    } res_sel_e;

    typedef struct packed {
        logic [3:0]       op;
        logic [IDX_W-1:0] idx;
    } sel_cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRED = 2'd2
    } arm_state_e;

    function automatic logic [NIB_W-1:0] nib_of(input logic [CH_W-1:0] s, input int n);
        return s[n*NIB_W +: NIB_W];
    endfunction

endpackage

// File: rtl/pat_trig_regport.sv
module pat_trig_regport
    import pat_trig_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [BYTE_W-1:0]  wr_data,
    output logic               row_we,
    output logic [IDX_W-1:0]   row_idx,
    output logic [NUM_NIB-1:0] row_bits,
    output logic               event_mode
);
    sel_cmd_t            cmd;
    logic                data_wr;
    logic                sel_wr;
    logic [PTR_W-1:0]    ptr_q;
    logic [NUM_NIB-1:0]  row_q;
    res_sel_e            res_q;
    logic                ptr_last;

    assign cmd      = sel_cmd_t'(wr_data);
    assign data_wr  = wr_en && !wr_sel;
    assign sel_wr   = wr_en && wr_sel;
    assign ptr_last = (ptr_q == PTR_W'(PARAM_BYTES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q      <= '0;
            row_q      <= '0;
            res_q      <= RES_OFF0;
            event_mode <= 1'b0;
        end else if (sel_wr) begin
            ptr_q <= '0;
        end else if (data_wr) begin
            if (ptr_q == PTR_W'(0))
                row_q <= wr_data[NUM_NIB-1:0];
            if (ptr_q == PTR_W'(1))
                res_q <= res_sel_e'(wr_data[RES_LSB +: 2]);
            if (ptr_last) begin
                ptr_q      <= '0;
                event_mode <= (res_q == RES_EVENT);
            end else begin
                ptr_q <= ptr_q + PTR_W'(1);
            end
        end
    end

    assign row_we   = sel_wr && (cmd.op == OP_ROW);
    assign row_idx  = cmd.idx;
    assign row_bits = row_q;

endmodule

// File: rtl/pat_trig_lut_bank.sv
module pat_trig_lut_bank
    import pat_trig_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               row_we,
    input  logic [IDX_W-1:0]   row_idx,
    input  logic [NUM_NIB-1:0] row_bits,
    input  logic [CH_W-1:0]    smp,
    output logic               match
);
    logic [NUM_NIB-1:0] grp_ok;

    for (genvar n = 0; n < NUM_NIB; n++) begin : g_tbl
        logic [TBL_D-1:0] tbl_q;

        always_ff @(posedge clk) begin
            if (rst)
                tbl_q <= '0;
            else if (row_we)
                tbl_q[row_idx] <= row_bits[n];
        end

        assign grp_ok[n] = tbl_q[nib_of(smp, n)];
    end

    assign match = &grp_ok;

endmodule

// File: rtl/pat_trig_arm_ctl.sv
module pat_trig_arm_ctl
    import pat_trig_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic smp_vld,
    input  logic match,
    input  logic event_mode,
    output logic trig_pulse,
    output logic trig_hit,
    output logic trig_armed
);
    arm_state_e st_q;
    logic       fire;

    assign fire = (st_q == ST_ARMED) && smp_vld && match && event_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            trig_pulse <= 1'b0;
        end else begin
            trig_pulse <= 1'b0;
            if (arm) begin
                st_q <= ST_ARMED;
            end else if (fire) begin
                st_q       <= ST_FIRED;
                trig_pulse <= 1'b1;
            end
        end
    end

    assign trig_hit   = (st_q == ST_FIRED);
    assign trig_armed = (st_q == ST_ARMED);

endmodule

// File: rtl/pat_trig.sv
module pat_trig
    import pat_trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              arm,
    input  logic              smp_vld,
    input  logic [CH_W-1:0]   smp,
    output logic              trig_pulse,
    output logic              trig_hit,
    output logic              trig_armed
);
    logic               row_we;
    logic [IDX_W-1:0]   row_idx;
    logic [NUM_NIB-1:0] row_bits;
    logic               event_mode;
    logic               lut_match;

    pat_trig_regport u_regport (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .row_we     (row_we),
        .row_idx    (row_idx),
        .row_bits   (row_bits),
        .event_mode (event_mode)
    );

    pat_trig_lut_bank u_lut (
        .clk      (clk),
        .rst      (rst),
        .row_we   (row_we),
        .row_idx  (row_idx),
        .row_bits (row_bits),
        .smp      (smp),
        .match    (lut_match)
    );

    pat_trig_arm_ctl u_arm (
        .clk        (clk),
        .rst        (rst),
        .arm        (arm),
        .smp_vld    (smp_vld),
        .match      (lut_match),
        .event_mode (event_mode),
        .trig_pulse (trig_pulse),
        .trig_hit   (trig_hit),
        .trig_armed (trig_armed)
    );

endmodule

// File: rtl/pat_trig_chk.sv
module pat_trig_chk (
    input logic clk,
    input logic rst,
    input logic arm,
    input logic smp_vld,
    input logic match,
    input logic event_mode,
    input logic trig_pulse,
    input logic trig_hit,
    input logic trig_armed
);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |=> !trig_pulse); // R8

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> $past(trig_armed && smp_vld && match && event_mode && !arm)); // R7

    AST_PULSE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> $past(event_mode)); // R6

    AST_HIT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (trig_hit && !arm) |=> trig_hit); // R8

    AST_HIT_XOR_ARMED: assert property (@(posedge clk) disable iff (rst)
        !(trig_hit && trig_armed)); // R8

    AST_ARM_WINS: assert property (@(posedge clk) disable iff (rst)
        arm |=> (trig_armed && !trig_hit && !trig_pulse)); // R10

    AST_INVALID_KEEPS_ARMED: assert property (@(posedge clk) disable iff (rst)
        (trig_armed && !smp_vld && !arm) |=> (trig_armed && !trig_pulse)); // R9

endmodule

bind pat_trig pat_trig_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .arm        (arm),
    .smp_vld    (smp_vld),
    .match      (lut_match),
    .event_mode (event_mode),
    .trig_pulse (trig_pulse),
    .trig_hit   (trig_hit),
    .trig_armed (trig_armed)
);

// File: tb/pat_trig_bench.sv
`timescale 1ns/1ps
module pat_trig_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        arm = 1'b0;
    logic        smp_vld = 1'b0;
    logic [15:0] smp = '0;
    logic        trig_pulse;
    logic        trig_hit;
    logic        trig_armed;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pat_trig u_pat_trig (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .arm        (arm),
        .smp_vld    (smp_vld),
        .smp        (smp),
        .trig_pulse (trig_pulse),
        .trig_hit   (trig_hit),
        .trig_armed (trig_armed)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Transposed row load; junk in unused row bits (R3)
    task automatic load_tables(input logic [3:0][15:0] t);
        for (int i = 0; i < 16; i++) begin
            wr(1'b0, {4'hA, t[3][i], t[2][i], t[1][i], t[0][i]});
            wr(1'b0, 8'hC3);
            wr(1'b1, 8'h30 | 8'(i));
        end
    endtask

    task automatic load_params(input logic [1:0] res);
        wr(1'b0, 8'hFD);
        wr(1'b0, {2'b01, 2'b10, res, 2'b11});
        wr(1'b0, 8'h12);
        wr(1'b0, 8'h34);
        wr(1'b0, 8'h56);
        wr(1'b0, 8'h78);
    endtask

    function automatic logic [3:0][15:0] mv_tables(input logic [15:0] mask, input logic [15:0] val);
        logic [3:0][15:0] t;
        for (int n = 0; n < 4; n++)
            for (int j = 0; j < 16; j++) begin
                logic ok = 1'b1;
                for (int k = 0; k < 4; k++)
                    if (mask[4*n+k] && (val[4*n+k] != j[k])) ok = 1'b0;
                t[n][j] = ok;
            end
        return t;
    endfunction

    // arm, present one valid sample, observe pulse after its edge
    task automatic try_sample(input logic [15:0] s, output logic obs);
        @(negedge clk); arm = 1'b1; smp_vld = 1'b0;
        @(negedge clk); arm = 1'b0; smp_vld = 1'b1; smp = s;
        @(negedge clk); smp_vld = 1'b0; obs = trig_pulse;
    endtask

    task automatic sweep_mv(input logic [15:0] mask, input logic [15:0] val);
        logic obs;
        load_tables(mv_tables(mask, val));
        for (int b = -1; b < 16; b++) begin
            logic [15:0] s = (b < 0) ? val : (val ^ (16'h1 << b));
            try_sample(s, obs);
            chk(obs, (((s ^ val) & mask) == 0), "R2 mask/value neighbour");
        end
        for (int i = 0; i < 2048; i++) begin
            logic [15:0] s = 16'(i * 40503) ^ (val & 16'hF0F0);
            try_sample(s, obs);
            chk(obs, (((s ^ val) & mask) == 0), "R3 row-load sweep");
        end
    endtask

    initial begin
        logic obs;
        logic [3:0][15:0] ft;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(trig_pulse, 0, "R1 reset pulse");
        chk(trig_hit, 0, "R1 reset hit");
        chk(trig_armed, 0, "R1 reset armed");
        try_sample(16'h0000, obs); chk(obs, 0, "R1 empty tables 0000");
        try_sample(16'hFFFF, obs); chk(obs, 0, "R1 empty tables FFFF");

        // all-ones tables, no parameter block yet
        load_tables(mv_tables(16'h0000, 16'h0000));
        try_sample(16'h1234, obs); chk(obs, 0, "R6 no params");
        load_params(2'd2);
        try_sample(16'h1234, obs); chk(obs, 0, "R6 result select 2");
        load_params(2'd3);
        try_sample(16'h1234, obs); chk(obs, 1, "R6 result select 3");

        // R7 latency and R8 one-shot
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0; smp_vld = 1'b1; smp = 16'hBEEF;
        chk(trig_pulse, 0, "R7 no pulse before edge");
        @(negedge clk);
        chk(trig_pulse, 1, "R7 pulse after edge");
        chk(trig_hit, 1, "R8 hit set");
        @(negedge clk);
        chk(trig_pulse, 0, "R8 pulse one cycle");
        chk(trig_hit, 1, "R8 hit held");
        chk(trig_armed, 0, "R8 not armed");
        smp_vld = 1'b0;
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
        chk(trig_hit, 0, "R8 re-arm clears hit");
        chk(trig_armed, 1, "R8 re-armed");

        // R9 invalid sample while armed
        smp = 16'hBEEF; smp_vld = 1'b0;
        @(negedge clk);
        chk(trig_pulse, 0, "R9 invalid sample no pulse");
        chk(trig_armed, 1, "R9 still armed");
        smp_vld = 1'b1;
        @(negedge clk); smp_vld = 1'b0;
        chk(trig_pulse, 1, "R9 valid sample fires");

        // R10 arm with matching sample in same cycle
        @(negedge clk); arm = 1'b1; smp_vld = 1'b1;
        @(negedge clk); arm = 1'b0;
        chk(trig_pulse, 0, "R10 arm beats match");
        chk(trig_armed, 1, "R10 armed");
        @(negedge clk); smp_vld = 1'b0;
        chk(trig_pulse, 1, "R10 next sample fires");

        // R4: wrong opcode must not write; R5: row reuse
        wr(1'b0, 8'h00);
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h25);
        try_sample(16'h5555, obs); chk(obs, 1, "R4 opcode 2 ignored");
        wr(1'b1, 8'h35);
        try_sample(16'h5555, obs); chk(obs, 0, "R5 reused zero row");
        try_sample(16'h4444, obs); chk(obs, 1, "R5 other rows intact");

        // R2/R3 sweeps
        sweep_mv(16'hFFFF, 16'hA5C3);
        sweep_mv(16'h0F0F, 16'h1234);
        sweep_mv(16'h8421, 16'hFFFF);
        sweep_mv(16'hF00F, 16'h700E);

        // free-form tables
        ft[0] = 16'h8001; ft[1] = 16'hFFFF; ft[2] = 16'h0F0F; ft[3] = 16'hFFF0;
        load_tables(ft);
        for (int i = 0; i < 2048; i++) begin
            logic [15:0] s = 16'(i * 7919);
            logic e = ft[0][s[3:0]] & ft[1][s[7:4]] & ft[2][s[11:8]] & ft[3][s[15:12]];
            try_sample(s, obs);
            chk(obs, e, "R2 free-form tables");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule